// File: doc/BRIEF.md
# Cross-Domain Short Pause Counter

This block gives software a short, precise wait that is timed by the oscillator clock while being started and polled from the register clock domain. A nonzero value written on the register side is carried to the oscillator domain, where a down counter is loaded with it and decremented once per oscillator cycle until it reaches zero. The register side sees a single busy bit that stays high from the write until the countdown has ended. A very small load is raised to a configured floor, so the shortest wait is never shorter than that floor.

The load crosses domains with a toggle request and a toggle acknowledge. The running state comes back through a synchronizer chain. While a transfer is in flight the value on the crossing is held still. A write that arrives during that time waits in a one-entry slot, where a later write replaces an earlier one. Resynchronising the end of the count costs a fixed number of register cycles, and the counter does not subtract them from the wait.

Top module: `pause_timer`

## Requirements
- R1: After reset in both domains `busy` reads 0 and the counter is idle.
- R2: A write with `wr_en` high and nonzero `wr_data` sets `busy` to 1 in the register cycle right after the edge that samples it.
- R3: The oscillator-domain counter is loaded with the effective value and drops by one on each oscillator edge, so the busy time grows by exactly one oscillator period for each unit of the written value.
- R4: The counter holds at zero and never wraps. The all-ones value counts down fully.
- R5: A written value from 1 up to MIN_COUNT-1 gives the same busy time as MIN_COUNT.
- R6: A write of zero has no effect. It neither starts an idle counter nor stops or changes a running countdown.
- R7: A nonzero write while a countdown runs (with no transfer in flight) restarts the counter from the new value. The busy time, measured from that write, matches a fresh start.
- R8: While a transfer awaits its acknowledge, the value on the crossing is held stable. Further nonzero writes go to a one-entry slot where the latest write wins, and the slot is sent once the acknowledge returns.
- R9: `busy` stays 1 whenever a transfer is in flight, a slot entry waits, or the counter is nonzero. It falls only after the counter has reached zero, plus the SYNC_STAGES+1 register-cycle resynchronisation cost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| reg_clk | input | 1 | Register domain clock |
| reg_rst | input | 1 | Synchronous active-high reset, register domain |
| wr_en | input | 1 | Write strobe for the pause value |
| wr_data | input | CNT_WIDTH | Pause length in oscillator cycles; zero is ignored |
| busy | output | 1 | 1 while a pause is pending or counting, registered |
| osc_clk | input | 1 | Oscillator domain clock that times the pause |
| osc_rst | input | 1 | Synchronous active-high reset, oscillator domain |

## Verification
The bench builds the block with CNT_WIDTH set to 10, SYNC_STAGES 2 and MIN_COUNT 4. The narrower counter puts the full-scale value 1023 within the run length, so R4 is tested at the top of the range and not just argued. The oscillator period is exactly eight register periods, with a fixed phase offset, and every write is aligned to an oscillator edge. Each busy time is therefore an exact function of the value, so the floor, the restart and the ignored zero can each be checked to the cycle against a measured baseline.

// File: rtl/pause_pkg.sv
`timescale 1ns/1ps
package pause_pkg;
  localparam int unsigned PT_SYNC_DEFAULT = 2;
  localparam int unsigned PT_MIN_DEFAULT  = 4;

  // Status carried from the oscillator domain back to the register domain.
  typedef struct packed {
    logic ack;   // toggles once per accepted load
    logic run;   // counter is nonzero
  } osc_flags_t;
endpackage

// File: rtl/pause_sync.sv
`timescale 1ns/1ps
module pause_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned BITS   = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [BITS-1:0] d,
  output logic [BITS-1:0] q
);
  logic [STAGES-1:0][BITS-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pause_reg_side.sv
`timescale 1ns/1ps
module pause_reg_side import pause_pkg::*; #(
  parameter int unsigned CNT_WIDTH   = 16,
  parameter int unsigned SYNC_STAGES = PT_SYNC_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [CNT_WIDTH-1:0] wr_data,
  input  osc_flags_t           flags_async,
  output logic                 req_tgl,
  output logic [CNT_WIDTH-1:0] xfer_val,
  output logic                 busy
);
  localparam int unsigned FLAG_BITS = $bits(osc_flags_t);

  logic [FLAG_BITS-1:0] flags_vec_s;
  osc_flags_t           flags_s;

  pause_sync #(.STAGES(SYNC_STAGES), .BITS(FLAG_BITS)) u_flag_sync (
    .clk (clk),
    .rst (rst),
    .d   (flags_async),
    .q   (flags_vec_s)
  );
  assign flags_s = osc_flags_t'(flags_vec_s);

  logic                 req_q;
  logic [CNT_WIDTH-1:0] val_q;
  logic                 slot_v_q;
  logic [CNT_WIDTH-1:0] slot_d_q;
  logic                 in_flight_q;
  logic                 guard_q;
  logic                 busy_q;

  logic wr_go;
  logic in_flight;
  logic launch;

  assign wr_go     = wr_en && (wr_data != '0);
  assign in_flight = (req_q != flags_s.ack);
  assign launch    = !in_flight && (wr_go || slot_v_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= 1'b0;
      val_q       <= '0;
      slot_v_q    <= 1'b0;
      slot_d_q    <= '0;
      in_flight_q <= 1'b0;
      guard_q     <= 1'b0;
      busy_q      <= 1'b0;
    end else begin
      in_flight_q <= in_flight;
      guard_q     <= in_flight_q && !in_flight;
      if (!in_flight) begin
        slot_v_q <= 1'b0;
        if (launch) begin
          val_q <= wr_go ? wr_data : slot_d_q;
          req_q <= ~req_q;
        end
      end else if (wr_go) begin
        slot_v_q <= 1'b1;
        slot_d_q <= wr_data;
      end
      busy_q <= wr_go || slot_v_q || in_flight || in_flight_q || guard_q || flags_s.run;
    end
  end

  assign req_tgl  = req_q;
  assign xfer_val = val_q;
  assign busy     = busy_q;

  // R2: an accepted write shows as busy in the next cycle
  p_busy_on_write_r2: assert property (@(posedge clk) disable iff (rst)
    wr_go |=> busy);

  // R6: a zero write while idle launches nothing
  p_zero_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data == '0 && !in_flight && !slot_v_q) |=> $stable(req_tgl));

  // R8: the crossing value is frozen while awaiting the acknowledge
  p_hold_stable_r8: assert property (@(posedge clk) disable iff (rst)
    in_flight |=> $stable(xfer_val));

  // R9: busy covers any outstanding transfer or queued entry
  p_busy_cover_r9: assert property (@(posedge clk) disable iff (rst)
    (in_flight || slot_v_q) |-> busy);
endmodule

// File: rtl/pause_osc_side.sv
`timescale 1ns/1ps
module pause_osc_side import pause_pkg::*; #(
  parameter int unsigned CNT_WIDTH   = 16,
  parameter int unsigned SYNC_STAGES = PT_SYNC_DEFAULT,
  parameter int unsigned MIN_COUNT   = PT_MIN_DEFAULT
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_async,
  input  logic [CNT_WIDTH-1:0] val_async,
  output osc_flags_t           flags
);
  localparam logic [CNT_WIDTH-1:0] MIN_VAL = CNT_WIDTH'(MIN_COUNT);
  localparam logic [CNT_WIDTH-1:0] CNT_ONE = CNT_WIDTH'(1);

  logic req_s;
  pause_sync #(.STAGES(SYNC_STAGES), .BITS(1)) u_req_sync (
    .clk (clk),
    .rst (rst),
    .d   (req_async),
    .q   (req_s)
  );

  logic                 seen_q;
  logic [CNT_WIDTH-1:0] cnt_q;
  logic [CNT_WIDTH-1:0] cnt_d;
  logic                 ack_pend_q;
  logic                 ack_q;
  logic                 run_q;
  logic                 new_req;
  logic [CNT_WIDTH-1:0] load_val;

  assign new_req  = (req_s != seen_q);
  // the value is quasi-static here: it changed before the request toggle
  assign load_val = (val_async < MIN_VAL) ? MIN_VAL : val_async;

  always_comb begin
    cnt_d = cnt_q;
    if (new_req)            cnt_d = load_val;
    else if (cnt_q != '0)   cnt_d = cnt_q - CNT_ONE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q     <= 1'b0;
      cnt_q      <= '0;
      ack_pend_q <= 1'b0;
      ack_q      <= 1'b0;
      run_q      <= 1'b0;
    end else begin
      seen_q     <= req_s;
      cnt_q      <= cnt_d;
      run_q      <= (cnt_d != '0);
      ack_pend_q <= new_req;
      if (ack_pend_q) ack_q <= ~ack_q;
    end
  end

  assign flags.ack = ack_q;
  assign flags.run = run_q;

  // R3: one step down per oscillator edge while nonzero
  p_step_down_r3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !new_req) |=> cnt_q == $past(cnt_q) - CNT_ONE);

  // R4: zero is a resting state, no wrap
  p_no_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !new_req) |=> cnt_q == '0);

  // R5: every load is at least the floor
  p_floor_r5: assert property (@(posedge clk) disable iff (rst)
    new_req |=> cnt_q >= MIN_VAL);

  // R8: each accepted load is acknowledged by one toggle
  p_ack_toggle_r8: assert property (@(posedge clk) disable iff (rst)
    ack_pend_q |=> ack_q != $past(ack_q));
endmodule

// File: rtl/pause_timer.sv
`timescale 1ns/1ps
module pause_timer import pause_pkg::*; #(
  parameter int unsigned CNT_WIDTH   = 16,
  parameter int unsigned SYNC_STAGES = PT_SYNC_DEFAULT,
  parameter int unsigned MIN_COUNT   = PT_MIN_DEFAULT
) (
  input  logic                 reg_clk,
  input  logic                 reg_rst,
  input  logic                 wr_en,
  input  logic [CNT_WIDTH-1:0] wr_data,
  output logic                 busy,
  input  logic                 osc_clk,
  input  logic                 osc_rst
);
  logic                 req_tgl;
  logic [CNT_WIDTH-1:0] xfer_val;
  osc_flags_t           flags;

  pause_reg_side #(.CNT_WIDTH(CNT_WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_reg (
    .clk         (reg_clk),
    .rst         (reg_rst),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .flags_async (flags),
    .req_tgl     (req_tgl),
    .xfer_val    (xfer_val),
    .busy        (busy)
  );

  pause_osc_side #(.CNT_WIDTH(CNT_WIDTH), .SYNC_STAGES(SYNC_STAGES),
                   .MIN_COUNT(MIN_COUNT)) u_osc (
    .clk       (osc_clk),
    .rst       (osc_rst),
    .req_async (req_tgl),
    .val_async (xfer_val),
    .flags     (flags)
  );

  // R1: idle after reset in the register domain
  p_reset_idle_r1: assert property (@(posedge reg_clk)
    $past(reg_rst) |-> !busy);
endmodule

// File: tb/test_pause_timer.sv
`timescale 1ns/1ps
module test_pause_timer;
  localparam int unsigned W     = 10;
  localparam int unsigned SYNC  = 2;
  localparam int unsigned MINC  = 4;
  localparam int unsigned RATIO = 8;      // oscillator period / register period
  localparam int          CAP   = 20000;

  // {written value, effective count}
  localparam int unsigned VEC [8][2] = '{
    '{1, 4}, '{2, 4}, '{3, 4}, '{4, 4},
    '{5, 5}, '{17, 17}, '{256, 256}, '{1023, 1023}
  };

  logic         reg_clk, reg_rst, wr_en, busy, osc_clk, osc_rst;
  logic [W-1:0] wr_data;

  int total = 0;
  int bad   = 0;
  int base  = 0;

  pause_timer #(.CNT_WIDTH(W), .SYNC_STAGES(SYNC), .MIN_COUNT(MINC)) i_pause_timer (
    .reg_clk (reg_clk),
    .reg_rst (reg_rst),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .busy    (busy),
    .osc_clk (osc_clk),
    .osc_rst (osc_rst)
  );

  initial begin
    reg_clk = 1'b0;
    forever #2.5 reg_clk = ~reg_clk;
  end

  initial begin
    osc_clk = 1'b0;
    #1;
    forever #20 osc_clk = ~osc_clk;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // aligned write; returns busy one register cycle after the sampling edge
  task automatic do_write(input logic [W-1:0] v, output logic rose);
    @(posedge osc_clk);
    @(negedge reg_clk);
    wr_en   = 1'b1;
    wr_data = v;
    @(negedge reg_clk);
    wr_en   = 1'b0;
    wr_data = '0;
    rose    = busy;
  endtask

  task automatic measure(output int n);
    n = 1;
    while (busy !== 1'b0 && n < CAP) begin
      @(negedge reg_clk);
      n++;
    end
  endtask

  initial begin
    #1500000;
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic rose;
    int   d;
    int   unsigned eff;
    wr_en   = 1'b0;
    wr_data = '0;
    reg_rst = 1'b1;
    osc_rst = 1'b1;
    repeat (4) @(posedge osc_clk);
    @(negedge reg_clk);
    reg_rst = 1'b0;
    osc_rst = 1'b0;
    repeat (3) @(negedge reg_clk);
    check(busy === 1'b0, "R1 reset busy", int'(busy), 0);

    // baseline at the floor value
    do_write(W'(MINC), rose);
    check(rose === 1'b1, "R2 busy rise", int'(rose), 1);
    measure(base);
    check(base >= int'(MINC * RATIO) && base <= int'(MINC * RATIO + (SYNC + 2) * RATIO + SYNC + 4),
          "R9 baseline window", base, int'(MINC * RATIO));

    // table walk
    foreach (VEC[i]) begin
      repeat (5) @(negedge reg_clk);
      do_write(W'(VEC[i][0]), rose);
      check(rose === 1'b1, "R2 busy rise", int'(rose), 1);
      measure(d);
      eff = VEC[i][1];
      if (VEC[i][0] < MINC)
        check(d == base, "R5 floor", d, base);
      else if (VEC[i][0] == (1 << W) - 1)
        check(d == base + int'((eff - MINC) * RATIO), "R4 full scale", d, base + int'((eff - MINC) * RATIO));
      else
        check(d == base + int'((eff - MINC) * RATIO), "R3 duration", d, base + int'((eff - MINC) * RATIO));
    end

    // zero write while idle: busy must stay low
    repeat (5) @(negedge reg_clk);
    @(negedge reg_clk);
    wr_en   = 1'b1;
    wr_data = '0;
    @(negedge reg_clk);
    wr_en = 1'b0;
    begin
      int seen = 0;
      for (int k = 0; k < 60; k++) begin
        if (busy !== 1'b0) seen++;
        @(negedge reg_clk);
      end
      check(seen == 0, "R6 zero idle", seen, 0);
    end

    // zero write during a running count: duration unchanged
    do_write(W'(50), rose);
    d = 1;
    while (busy !== 1'b0 && d < CAP) begin
      @(negedge reg_clk);
      d++;
      if (d == 30) begin
        wr_en   = 1'b1;
        wr_data = '0;
      end else begin
        wr_en = 1'b0;
      end
    end
    wr_en = 1'b0;
    check(d == base + int'((50 - MINC) * RATIO), "R6 zero during run", d, base + int'((50 - MINC) * RATIO));

    // restart while running
    do_write(W'(500), rose);
    repeat (100) @(negedge reg_clk);
    do_write(W'(10), rose);
    measure(d);
    check(d == base + int'((10 - MINC) * RATIO), "R7 restart", d, base + int'((10 - MINC) * RATIO));

    // writes during an outstanding transfer: latest slot entry wins
    repeat (5) @(negedge reg_clk);
    @(posedge osc_clk);
    @(negedge reg_clk);
    wr_en   = 1'b1;
    wr_data = W'(1000);
    @(negedge reg_clk);
    wr_data = W'(900);
    @(negedge reg_clk);
    wr_data = W'(6);
    @(negedge reg_clk);
    wr_en   = 1'b0;
    wr_data = '0;
    measure(d);
    check(d >= base + int'((6 - MINC) * RATIO), "R8 slot lower", d, base + int'((6 - MINC) * RATIO));
    check(d <= base + int'((6 - MINC) * RATIO) + 80, "R8 slot upper", d, base + int'((6 - MINC) * RATIO) + 80);
    check(busy === 1'b0, "R9 busy falls", int'(busy), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule